// File: doc/BRIEF.md
# Read-Only I2C Sample Target

This block is the bus side of a 12-bit sampling converter that can only be read over I2C. It watches the serial clock and data lines through two-stage synchronizers and drives the data line open-drain through a single pull-low enable. It recognises START and STOP, and it accepts a 7-bit target address built from a fixed 4-bit device code and three strap inputs. It answers only read requests. For each conversion it sends two bytes: first four zero bits followed by the top nibble of the sample, then the low eight bits.

An external sampler is told when to take a new value through a one-cycle capture pulse. The block latches the 12-bit value presented on the sample input in the following clock cycle, and holds it while it is shifted out. If the bus master acknowledges the low byte, the block keeps streaming fresh samples for as long as the master keeps acknowledging. A not-acknowledge or a STOP ends the stream. A START at any point restarts address reception.

Top module: `i2c_sample_target`

## Requirements
- R1: An address byte whose top four bits are 1,0,0,1, whose next three bits equal `strap_i[2:0]` (MSB first) and whose eighth bit (read/write) is 1 is acknowledged: `sda_oe` is high during the ninth SCL pulse, so the bus reads 0.
- R2: After an address that does not match, or after a matching address with read/write 0, the block never drives SDA and produces no capture pulse until the next START.
- R3: The first capture pulse comes from the SCL falling edge that ends the read/write bit. It is exactly one clock wide, and no pulse occurs during the seven address bits.
- R4: The first data byte after the address acknowledge is 0,0,0,0 followed by sample bits 11 down to 8, sent MSB first.
- R5: After the master acknowledges the upper byte (SDA low on the ninth clock), the next eight clocks carry sample bits 7 down to 0, MSB first.
- R6: A master not-acknowledge (SDA high) after a data byte makes the block release SDA. It then drives nothing and produces no capture pulse until the next START.
- R7: Every low byte's LSB ends with a capture pulse on that SCL falling edge. If the master then acknowledges, the block sends a new upper/lower pair built from the newly captured sample.
- R8: The sample is latched one clock after the capture pulse and holds while it is transmitted, whatever `sample_i` does afterwards.
- R9: START (SDA falling while SCL is high) at any point, including in the middle of an address byte, restarts address reception. START and STOP (SDA rising while SCL is high) both release SDA.
- R10: After reset SDA is released and no capture pulse is present. `sda_oe` changes only in the clock after a synchronized SCL falling edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Low three address bits of the target |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sample_i | input | 12 | Value from the external sampler |
| cap_strobe | output | 1 | One-cycle request to capture a new sample |

## Verification
Each strap setting is read once with a matching address, so that acknowledge generation and the two-byte framing are checked against a fresh sample each time. All 128 seven-bit addresses are then tried against one strap value. This separates a correct match from one that ignores a device-code bit or a strap bit, and a write to the correct address shows that the read/write bit is part of the decision. A sixteen-sample stream uses all-ones, all-zeros and arithmetic patterns to show that every nibble and bit lands in its slot and that each pair comes from the newest capture. A START in the middle of an address byte shows that the bit counter restarts.

// File: rtl/i2c_sample_target.sv
module i2c_sample_target #(
  parameter logic [3:0] DEV_CODE = 4'b1001,
  parameter int         SMP_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       strap_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [SMP_W-1:0] sample_i,
  output logic             cap_strobe
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_TX, S_MACK} st_t;

  st_t              st;
  logic [1:0]       scl_sy, sda_sy;
  logic             scl_d, sda_d;
  logic [3:0]       cnt;
  logic [7:0]       sh;
  logic             lo_q, mack_q;
  logic [SMP_W-1:0] data_q;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  wire [15:0] word = 16'(data_q);
  wire addr_ok = (sh[7:4] == DEV_CODE) && (sh[3:1] == strap_i) && sh[0];

  assign sda_oe = (st == S_AACK) | ((st == S_TX) & ~sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      lo_q       <= 1'b0;
      mack_q     <= 1'b0;
      cap_strobe <= 1'b0;
      data_q     <= '0;
    end else begin
      cap_strobe <= 1'b0;
      if (cap_strobe) data_q <= sample_i;
      if (start_c) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
      end else begin
        unique case (st)
          S_ADDR: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (addr_ok) begin
                st         <= S_AACK;
                cap_strobe <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            st   <= S_TX;
            sh   <= word[15:8];
            cnt  <= '0;
            lo_q <= 1'b0;
          end
          S_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              st <= S_MACK;
              if (lo_q) cap_strobe <= 1'b1;
            end else begin
              sh  <= {sh[6:0], 1'b1};
              cnt <= cnt + 4'd1;
            end
          end
          S_MACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                st   <= S_TX;
                cnt  <= '0;
                lo_q <= ~lo_q;
                sh   <= lo_q ? word[15:8] : word[7:0];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_sample_target_chk.sv
module i2c_sample_target_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_fall,
  input logic         start_c,
  input logic         stop_c,
  input logic         sda_oe,
  input logic         cap_strobe,
  input logic [W-1:0] data_q
);

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> !cap_strobe);

  p_strobe_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> $past(scl_fall));

  p_hold_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_strobe) |-> $stable(data_q));

  p_release_on_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> !sda_oe);

  p_drive_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_c || stop_c));

endmodule

bind i2c_sample_target i2c_sample_target_chk #(.W(SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_c(start_c),
  .stop_c(stop_c), .sda_oe(sda_oe), .cap_strobe(cap_strobe), .data_q(data_q)
);

// File: tb/i2c_sample_target_tb_top.sv
module i2c_sample_target_tb_top;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        m_scl = 1'b1;
  logic        m_low = 1'b0;
  logic [2:0]  strap = 3'd0;
  logic [11:0] smp = 12'hFFF;
  logic        oe, stb;
  wire         sda_bus = ~(oe | m_low);

  int vecs = 0, miss = 0, strobes = 0, k = 1;
  logic [11:0] last_cap = '0;
  logic pend = 1'b0;

  i2c_sample_target dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(oe), .sample_i(smp), .cap_strobe(stb)
  );

  function automatic logic [11:0] gen(input int n);
    if (n == 1) return 12'h000;
    return 12'((n * 2897) ^ (n << 7));
  endfunction

  always @(negedge clk) begin
    if (stb) begin
      last_cap = smp;
      pend = 1'b1;
      strobes++;
    end else if (pend) begin
      smp = gen(k);
      k++;
      pend = 1'b0;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string r, input int a, input int e);
    vecs++;
    if (a != e) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic bstart();
    m_low = 1'b0; wt(3); m_scl = 1'b1; wt(H); m_low = 1'b1; wt(H); m_scl = 1'b0; wt(3);
  endtask

  task automatic bstop();
    m_low = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_low = 1'b0; wt(H);
  endtask

  task automatic wbit(input logic b);
    m_low = !b; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(3);
  endtask

  task automatic rbit(output logic b);
    m_low = 1'b0; wt(H); m_scl = 1'b1; wt(H/2); b = sda_bus; wt(H - H/2); m_scl = 1'b0; wt(3);
  endtask

  task automatic rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
  endtask

  task automatic addr(input logic [6:0] a, input logic rw);
    for (int i = 6; i >= 0; i--) wbit(a[i]);
    wbit(rw);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecs++; miss++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    logic b;
    logic [7:0] v;
    logic [11:0] e;
    int c;
    wt(4); rst_n = 1'b1; wt(5);
    chk("R10 reset oe", int'(oe), 0);
    chk("R10 reset strobe", int'(stb), 0);

    // R1 R3 R4 R5 R6 across every strap value
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      bstart();
      c = strobes;
      for (int i = 6; i >= 0; i--) wbit(((7'h48 | 7'(s)) >> i) & 1'b1);
      chk("R3 no strobe in address", strobes, c);
      wbit(1'b1); wt(3);
      chk("R3 strobe at rw fall", strobes, c + 1);
      rbit(b); chk("R1 ack", int'(b), 0);
      e = last_cap;
      rbyte(v); chk("R4 upper byte", int'(v), int'({4'h0, e[11:8]}));
      wbit(1'b0);
      rbyte(v); chk("R5 lower byte", int'(v), int'(e[7:0]));
      wbit(1'b1); wt(3);
      c = strobes;
      rbyte(v); chk("R6 released after nak", int'(v), 8'hFF);
      chk("R6 no strobe after nak", strobes, c);
      bstop();
    end

    // R2 sweep of all addresses against strap 3
    strap = 3'd3;
    for (int a = 0; a < 128; a++) begin
      bstart();
      addr(7'(a), 1'b1); wt(3);
      c = strobes;
      rbit(b);
      if (a == 7'h4B) begin
        chk("R1 ack match", int'(b), 0);
        e = last_cap;
        rbyte(v); chk("R4 upper byte", int'(v), int'({4'h0, e[11:8]}));
        wbit(1'b1);
      end else begin
        chk("R2 no ack mismatch", int'(b), 1);
        rbyte(v); chk("R2 bus idle mismatch", int'(v), 8'hFF);
        chk("R2 no strobe mismatch", strobes, c);
      end
      bstop();
    end
    bstart(); c = strobes;
    addr(7'h4B, 1'b0);
    rbit(b); chk("R2 no ack write", int'(b), 1);
    rbyte(v); chk("R2 bus idle write", int'(v), 8'hFF);
    chk("R2 no strobe write", strobes, c);
    bstop();

    // R7 R8 continuous stream
    strap = 3'd6;
    bstart(); addr(7'h4E, 1'b1);
    rbit(b); chk("R1 ack stream", int'(b), 0);
    e = last_cap;
    for (int n = 0; n < 16; n++) begin
      rbyte(v); chk("R7 stream upper", int'(v), int'({4'h0, e[11:8]}));
      wbit(1'b0);
      c = strobes;
      rbyte(v); chk("R8 stream lower", int'(v), int'(e[7:0]));
      wt(3);
      chk("R7 strobe at lsb fall", strobes, c + 1);
      e = last_cap;
      wbit(n == 15);
    end
    bstop();

    // R9 repeated START mid address
    strap = 3'd2;
    bstart();
    wbit(1'b1); wbit(1'b0); wbit(1'b0); wbit(1'b1);
    bstart();
    addr(7'h4A, 1'b1);
    rbit(b); chk("R9 ack after restart", int'(b), 0);
    e = last_cap;
    rbyte(v); chk("R9 upper after restart", int'(v), int'({4'h0, e[11:8]}));
    wbit(1'b1);
    bstop(); wt(5);
    chk("R9 released after stop", int'(oe), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule